// File: doc/BRIEF.md
# Satellite Tone Gating Controller

This block produces the logic-level 22 kHz tone gate for each LNB output channel of a satellite receiver supply. The gate drives an analog shaper, which sets amplitude and edge rates. Each channel has three inputs: an enable bit, a mode bit and a logic input. Together they select one of three behaviours:

- **External square wave.** The channel passes an external square wave through, but only after it has seen activity on the input.
- **Envelope.** The channel emits an internally divided 22 kHz tone while the input is high.
- **Continuous.** Envelope mode with the input held high gives a steady tone.

In the external mode, activity detection opens the gate about 1 µs after the first input edge. The gate closes again about 60 µs after the last edge. A 22 kHz period is about 45 µs, so a running square wave keeps the gate open between its edges. All delays are counted in system clock cycles. They are derived from a clock frequency parameter and rounded to the nearest cycle. The channels are identical and fully independent.

Top module: `tone_gate_ctrl`

## Requirements

Cycle figures below assume the default 125 MHz clock. This gives an onset of 125 cycles, a hold of 7500 cycles and a tone half period of 2841 cycles.

- R1: While `rst_ni` is low, and after release until an enable is set, every `tone_o` bit is low.
- R2: When a channel's `ten_i` bit is 0, its `tone_o` bit is low from the next clock, in every mode. Its timers and divider return to their idle state.
- R3: The input passes through a two-flop synchronizer, and the output is registered. A `tone_o` bit can therefore be high only if its `dsq_i` bit was high three clocks earlier.
- R4: With `ten_i`=1 and `extm_i`=1, the first `dsq_i` edge opens the gate. `tone_o` first goes high 128 cycles (onset + 3) after the clock edge that samples the edge, within ±1 cycle.
- R5: In external mode, every synchronized `dsq_i` edge restarts the hold timer. If `dsq_i` stays high after its last rise, `tone_o` stays high for 7500 cycles (±1) and then falls.
- R6: In external mode, once the gate is open, a 22 kHz square wave on `dsq_i` appears on `tone_o` with the same period and duty cycle, delayed by three cycles. The gate does not close between edges.
- R7: With `ten_i`=1 and `extm_i`=0, `tone_o` is an internal 50 % duty tone with a half period of 2841 cycles while `dsq_i` is high.
  - The tone restarts in phase, high first, three cycles after `dsq_i` rises.
  - `tone_o` is low three cycles after `dsq_i` falls.
- R8: With `ten_i`=1, `extm_i`=0 and `dsq_i` held high, `tone_o` is a continuous tone with a period of 5682 cycles (±1).
- R9: Each channel depends only on its own `ten_i`, `extm_i` and `dsq_i` bits.
- R10: A change of `extm_i` while `ten_i`=1 takes effect on the next clock and cancels any open gate or pending hold. Switching into external mode is followed by a low `tone_o` until new input activity passes the onset delay.

## Ports

| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ten_i | input | NUM_CH | Tone enable, one bit per channel |
| extm_i | input | NUM_CH | Mode select per channel: 1 = external square wave, 0 = envelope |
| dsq_i | input | NUM_CH | Asynchronous tone/envelope logic input per channel |
| tone_o | output | NUM_CH | Registered tone gate output per channel |

## Verification

The assertions assume the following about the inputs:

- `ten_i` and `extm_i` are synchronous to `clk_i`.
- `dsq_i` may be asynchronous, but each level lasts longer than the synchronizer depth.

The assertions therefore rely on the fixed three-cycle path from `dsq_i` to `tone_o`. The envelope high-time bound counts only runs that start after the mode bit has settled to envelope.

The stimulus changes every input at the falling clock edge, so no input changes at a sampling edge. External square waves use the 2841-cycle half period, which stays far above the synchronizer depth and well below the 7500-cycle hold. Mode bits are changed only between tests, or deliberately for a single cycle to probe R10.

// File: rtl/tone_gate_pkg.sv
package tone_gate_pkg;

  typedef enum logic [1:0] {
    ACT_IDLE  = 2'd0,
    ACT_ONSET = 2'd1,
    ACT_OPEN  = 2'd2
  } act_state_e;

  // round(clk_hz * ns / 1e9)
  function automatic int unsigned ns_to_cycles(input longint unsigned clk_hz,
                                               input longint unsigned ns);
    longint unsigned v;
    v = (clk_hz * ns + 64'd500_000_000) / 64'd1_000_000_000;
    return 32'(v);
  endfunction

  // round(clk_hz / (2 * tone_hz))
  function automatic int unsigned half_period(input longint unsigned clk_hz,
                                              input longint unsigned tone_hz);
    longint unsigned v;
    v = (clk_hz + tone_hz) / (64'd2 * tone_hz);
    return 32'(v);
  endfunction

endpackage

// File: rtl/tone_sync.sv
module tone_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= d_i;
      end
    end else begin : g_multi
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= {chain_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/tone_div.sv
module tone_div #(
  parameter int unsigned HALF_CYC = 2841
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic sq_o
);

  localparam int unsigned CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_CYC - 1);

  logic [CW-1:0] cnt_q;
  logic          ph_q;

  // idle phase is high so a new run starts in phase
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ph_q  <= 1'b1;
    end else if (!run_i) begin
      cnt_q <= '0;
      ph_q  <= 1'b1;
    end else if (cnt_q == LAST) begin
      cnt_q <= '0;
      ph_q  <= ~ph_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign sq_o = ph_q;

endmodule

// File: rtl/tone_activity.sv
module tone_activity
  import tone_gate_pkg::*;
#(
  parameter int unsigned ONSET_CYC = 125,
  parameter int unsigned HOLD_CYC  = 7500
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic clr_i,
  input  logic lvl_i,
  output logic gate_o
);

  localparam int unsigned OW = (ONSET_CYC > 1) ? $clog2(ONSET_CYC) : 1;
  localparam int unsigned HW = (HOLD_CYC > 1) ? $clog2(HOLD_CYC) : 1;
  localparam logic [OW-1:0] ON_LAST   = OW'(ONSET_CYC - 1);
  localparam logic [HW-1:0] HOLD_LAST = HW'(HOLD_CYC - 1);

  act_state_e    st_q, st_d;
  logic [OW-1:0] on_q, on_d;
  logic [HW-1:0] quiet_q, quiet_d;
  logic          lvl_q;
  logic          edge_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= 1'b0;
    else         lvl_q <= lvl_i;
  end

  assign edge_w = lvl_i ^ lvl_q;

  always_comb begin
    st_d    = st_q;
    on_d    = on_q;
    quiet_d = quiet_q;
    if (clr_i || !en_i) begin
      st_d    = ACT_IDLE;
      on_d    = '0;
      quiet_d = '0;
    end else if (st_q == ACT_IDLE) begin
      if (edge_w) begin
        st_d    = ACT_ONSET;
        on_d    = '0;
        quiet_d = '0;
      end
    end else if (!edge_w && quiet_q == HOLD_LAST) begin
      // hold-off expired
      st_d    = ACT_IDLE;
      on_d    = '0;
      quiet_d = '0;
    end else begin
      quiet_d = edge_w ? '0 : quiet_q + 1'b1;
      if (st_q == ACT_ONSET) begin
        if (on_q == ON_LAST) st_d = ACT_OPEN;
        else                 on_d = on_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ACT_IDLE;
      on_q    <= '0;
      quiet_q <= '0;
    end else begin
      st_q    <= st_d;
      on_q    <= on_d;
      quiet_q <= quiet_d;
    end
  end

  assign gate_o = (st_q == ACT_OPEN);

endmodule

// File: rtl/tone_channel.sv
module tone_channel #(
  parameter int unsigned ONSET_CYC   = 125,
  parameter int unsigned HOLD_CYC    = 7500,
  parameter int unsigned HALF_CYC    = 2841,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ten_i,
  input  logic extm_i,
  input  logic dsq_i,
  output logic tone_o
);

  logic lvl_w, sq_w, gate_w, clr_w;
  logic extm_q, tone_q, tone_d;

  tone_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (dsq_i),
    .q_o   (lvl_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) extm_q <= 1'b0;
    else         extm_q <= extm_i;
  end

  // mode change cancels any pending gate
  assign clr_w = ~ten_i | (extm_i ^ extm_q);

  tone_activity #(.ONSET_CYC(ONSET_CYC), .HOLD_CYC(HOLD_CYC)) u_act (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (ten_i & extm_i),
    .clr_i (clr_w),
    .lvl_i (lvl_w),
    .gate_o(gate_w)
  );

  tone_div #(.HALF_CYC(HALF_CYC)) u_div (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (ten_i & ~extm_i & lvl_w),
    .sq_o  (sq_w)
  );

  assign tone_d = ten_i & (extm_i ? (gate_w & lvl_w) : (lvl_w & sq_w));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tone_q <= 1'b0;
    else         tone_q <= tone_d;
  end

  assign tone_o = tone_q;

endmodule

// File: rtl/tone_gate_ctrl.sv
module tone_gate_ctrl
  import tone_gate_pkg::*;
#(
  parameter int unsigned NUM_CH      = 2,
  parameter int unsigned CLK_HZ      = 125_000_000,
  parameter int unsigned TONE_HZ     = 22_000,
  parameter int unsigned ONSET_NS    = 1_000,
  parameter int unsigned HOLD_NS     = 60_000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] ten_i,
  input  logic [NUM_CH-1:0] extm_i,
  input  logic [NUM_CH-1:0] dsq_i,
  output logic [NUM_CH-1:0] tone_o
);

  localparam int unsigned ONSET_CYC = (ns_to_cycles(CLK_HZ, ONSET_NS) > 0) ?
                                      ns_to_cycles(CLK_HZ, ONSET_NS) : 1;
  localparam int unsigned HOLD_CYC  = (ns_to_cycles(CLK_HZ, HOLD_NS) > 0) ?
                                      ns_to_cycles(CLK_HZ, HOLD_NS) : 1;
  localparam int unsigned HALF_CYC  = (half_period(CLK_HZ, TONE_HZ) > 0) ?
                                      half_period(CLK_HZ, TONE_HZ) : 1;

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      tone_channel #(
        .ONSET_CYC  (ONSET_CYC),
        .HOLD_CYC   (HOLD_CYC),
        .HALF_CYC   (HALF_CYC),
        .SYNC_STAGES(SYNC_STAGES)
      ) u_ch (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .ten_i (ten_i[c]),
        .extm_i(extm_i[c]),
        .dsq_i (dsq_i[c]),
        .tone_o(tone_o[c])
      );
    end
  endgenerate

endmodule

// File: rtl/tone_gate_ctrl_chk.sv
module tone_gate_ctrl_chk
  import tone_gate_pkg::*;
#(
  parameter int unsigned NUM_CH      = 2,
  parameter int unsigned CLK_HZ      = 125_000_000,
  parameter int unsigned TONE_HZ     = 22_000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [NUM_CH-1:0] ten_i,
  input logic [NUM_CH-1:0] extm_i,
  input logic [NUM_CH-1:0] dsq_i,
  input logic [NUM_CH-1:0] tone_o
);

  localparam int unsigned HALF_CYC = half_period(CLK_HZ, TONE_HZ);
  localparam int unsigned LAT      = SYNC_STAGES + 1;

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
      logic [31:0] env_run_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                       env_run_q <= '0;
        else if (!tone_o[c] || extm_i[c])  env_run_q <= '0;
        else                               env_run_q <= env_run_q + 1;
      end

      assert_ten_off_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !ten_i[c] |=> !tone_o[c]);

      assert_input_path_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tone_o[c] |-> $past(dsq_i[c], LAT));

      assert_env_half_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        env_run_q <= HALF_CYC + 1);

      assert_mode_switch_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ten_i[c] && $past(ten_i[c]) && extm_i[c] && !$past(extm_i[c])) |=> !tone_o[c]);
    end
  endgenerate

endmodule

bind tone_gate_ctrl tone_gate_ctrl_chk #(
  .NUM_CH     (NUM_CH),
  .CLK_HZ     (CLK_HZ),
  .TONE_HZ    (TONE_HZ),
  .SYNC_STAGES(SYNC_STAGES)
) u_chk (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .ten_i (ten_i),
  .extm_i(extm_i),
  .dsq_i (dsq_i),
  .tone_o(tone_o)
);

// File: tb/tone_gate_ctrl_test.sv
module tone_gate_ctrl_test;

  localparam int NCH   = 2;
  localparam int ONSET = 125;   // 1 us at 125 MHz
  localparam int HOLD  = 7500;  // 60 us
  localparam int HALF  = 2841;  // 125e6 / 44e3 rounded

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [NCH-1:0] ten = '0, extm = '0, dsq = '0;
  logic [NCH-1:0] tone;

  int  checks = 0, fails = 0;
  bit  done = 0;

  always #4 clk = ~clk;

  tone_gate_ctrl uut (
    .clk_i (clk),
    .rst_ni(rst_n),
    .ten_i (ten),
    .extm_i(extm),
    .dsq_i (dsq),
    .tone_o(tone)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  // behavioural reference, one entry per channel
  bit m_h1[NCH], m_h2[NCH], m_h3[NCH], m_xp[NCH], m_ph[NCH], m_out[NCH];
  int m_st[NCH], m_on[NCH], m_qt[NCH], m_dc[NCH];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NCH; c++) begin
        m_h1[c] = 0; m_h2[c] = 0; m_h3[c] = 0; m_xp[c] = 0;
        m_ph[c] = 1; m_out[c] = 0;
        m_st[c] = 0; m_on[c] = 0; m_qt[c] = 0; m_dc[c] = 0;
      end
    end else begin
      for (int c = 0; c < NCH; c++) begin
        bit clr, edg, nout;
        clr  = !ten[c] || (extm[c] != m_xp[c]);
        edg  = m_h2[c] != m_h3[c];
        nout = ten[c] && (extm[c] ? (m_st[c] == 2 && m_h2[c]) : (m_h2[c] && m_ph[c]));
        if (ten[c] && !extm[c] && m_h2[c]) begin
          if (m_dc[c] == HALF - 1) begin m_dc[c] = 0; m_ph[c] = !m_ph[c]; end
          else m_dc[c]++;
        end else begin
          m_dc[c] = 0; m_ph[c] = 1;
        end
        if (clr || !extm[c]) begin
          m_st[c] = 0; m_on[c] = 0; m_qt[c] = 0;
        end else if (m_st[c] == 0) begin
          if (edg) begin m_st[c] = 1; m_on[c] = 0; m_qt[c] = 0; end
        end else if (!edg && m_qt[c] == HOLD - 1) begin
          m_st[c] = 0; m_on[c] = 0; m_qt[c] = 0;
        end else begin
          m_qt[c] = edg ? 0 : m_qt[c] + 1;
          if (m_st[c] == 1) begin
            if (m_on[c] == ONSET - 1) m_st[c] = 2;
            else m_on[c]++;
          end
        end
        m_out[c] = nout;
        m_h3[c] = m_h2[c]; m_h2[c] = m_h1[c]; m_h1[c] = dsq[c]; m_xp[c] = extm[c];
      end
    end
  end

  // every-cycle comparison against the model (R3, R9 over all patterns)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      for (int c = 0; c < NCH; c++)
        check(tone[c] == m_out[c], c == 0 ? "R3 ch0 model" : "R9 ch1 model",
              "tone vs reference", tone[c], m_out[c]);
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    check(0, "WATCHDOG", "run did not finish", 0, 1);
    summary();
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // count falling edges until tone[ch] == val
  task automatic wait_lvl(input int ch, input bit val, input int cap, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (tone[ch] != val && n < cap);
  endtask

  initial begin
    int n, h, l;
    // R1 reset
    cyc(5);
    check(tone == '0, "R1", "tone in reset", tone, 0);
    rst_n = 1'b1;
    cyc(3);
    check(tone == '0, "R1", "tone after reset", tone, 0);

    // R4 onset, R6 passthrough, R5 hold
    ten[0] = 1; extm[0] = 1;
    cyc(10);
    dsq[0] = 1;
    wait_lvl(0, 1, 400, n);
    check(n >= ONSET + 3 && n <= ONSET + 5, "R4", "onset cycles", n, ONSET + 4);
    cyc(HALF - n);
    for (int i = 0; i < 5; i++) begin
      dsq[0] = ~dsq[0];
      cyc(HALF / 2);
      check(tone[0] == dsq[0], "R6", "passthrough mid-half", tone[0], dsq[0]);
      cyc(HALF - HALF / 2);
    end
    dsq[0] = 1;
    wait_lvl(0, 1, 10, n);
    wait_lvl(0, 0, HOLD + 100, h);
    check(n + h >= HOLD + 3 && n + h <= HOLD + 5, "R5", "hold release cycle", n + h, HOLD + 4);
    dsq[0] = 0;
    cyc(20);

    // R7 envelope on ch1 while ch0 idles (R9)
    ten[1] = 1; extm[1] = 0;
    cyc(5);
    dsq[1] = 1;
    wait_lvl(1, 1, 20, n);
    check(n >= 2 && n <= 4, "R7", "envelope start", n, 3);
    wait_lvl(1, 0, 3 * HALF, h);
    check(h >= HALF - 1 && h <= HALF + 1, "R7", "tone high half", h, HALF);
    wait_lvl(1, 1, 3 * HALF, l);
    check(l >= HALF - 1 && l <= HALF + 1, "R7", "tone low half", l, HALF);
    check(tone[0] == 0, "R9", "ch0 quiet while ch1 runs", tone[0], 0);

    // R8 continuous tone period
    wait_lvl(1, 0, 3 * HALF, n);
    wait_lvl(1, 1, 3 * HALF, n);
    wait_lvl(1, 0, 3 * HALF, h);
    wait_lvl(1, 1, 3 * HALF, l);
    check(h + l >= 2 * HALF - 1 && h + l <= 2 * HALF + 1, "R8", "continuous period", h + l, 2 * HALF);
    dsq[1] = 0;
    cyc(4);
    check(tone[1] == 0, "R7", "envelope closes", tone[1], 0);

    // R2 enable low forces output low; ch1 keeps running (R9)
    dsq[1] = 1;
    cyc(HALF / 2);
    ten[1] = 0;
    cyc(2);
    check(tone[1] == 0, "R2", "ch1 disabled", tone[1], 0);
    ten[1] = 1;
    ten[0] = 0; extm[0] = 1;
    h = 0;
    for (int i = 0; i < 4; i++) begin
      dsq[0] = ~dsq[0];
      cyc(HALF / 2);
      check(tone[0] == 0, "R2", "ch0 disabled with activity", tone[0], 0);
      if (tone[1]) h++;
      cyc(HALF - HALF / 2);
    end
    check(h > 0, "R9", "ch1 tone while ch0 disabled", h, 1);
    dsq[1] = 0;

    // R10 mode switch cancels pending hold
    ten[0] = 1; extm[0] = 1; dsq[0] = 0;
    cyc(10);
    dsq[0] = 1;
    wait_lvl(0, 1, 400, n);
    check(tone[0] == 1, "R10", "gate open before switch", tone[0], 1);
    cyc(100);
    extm[0] = 0;
    cyc(1);
    extm[0] = 1;
    cyc(10);
    check(tone[0] == 0, "R10", "hold cancelled", tone[0], 0);
    cyc(HOLD / 2);
    check(tone[0] == 0, "R10", "stays low without activity", tone[0], 0);
    dsq[0] = 0;
    cyc(10);
    summary();
  end

endmodule